// File: doc/BRIEF.md
# Modular Constant Inner-Product Cell

This block evaluates a fixed weighted sum of residues on a small integer ring: given a set of residue inputs `x_t`, it produces `z = (c_0*x_0 + c_1*x_1 + ... ) mod m`. The modulus `m`, the number of terms and the weights `c_t` are elaboration-time parameters. The residue width is `B = ceil(log2 m)`. It is meant as a building block inside residue-arithmetic datapaths, for example a stage of a residue-to-binary converter, where many such cells with different constants are instantiated.

Each weight is applied through a small lookup table that is built from gates at elaboration, so there is no memory macro. The table is addressed by the B-bit residue. The partial products are combined by a chain of ordinary binary adders. Whenever an addition carries out of bit B-1, the lost `2^B` is replaced by its residue `2^B mod m`, which is added back in. A conditional subtraction of `m` then keeps every partial sum inside `0..m-1`. When `m` is a power of two, the fold constant is zero and the cell reduces to a truncating adder.

The inputs are captured into a register stage when `inValid` is high. The result is registered one cycle later and flagged by `outValid`.

Top module: `modConstDot`

## Requirements
- R1: While `rstN` is low, and after its release until the first accepted input, `outValid` is 0 and `zOut` is 0.
- R2: A vector on `xIn` sampled at a rising edge with `inValid` high appears on `zOut` at the second rising edge after it, with `outValid` high for exactly that cycle. The value is `(sum over t of c_t*x_t) mod m`, and term `t` occupies bits `[t*B +: B]` of `xIn`.
- R3: Whenever `outValid` is high, `zOut` is strictly less than `m`.
- R4: Sums whose binary additions carry out of B bits, including every input at `m-1`, still give the exact residue.
- R5: An input field holding a value of `m` or more contributes zero to the sum.
- R6: While no vector is accepted, `zOut` holds its last result and `outValid` stays low, whatever `xIn` carries.
- R7: Vectors presented on consecutive cycles each give their own result, one per cycle, in the order they were presented.
- R8: With a power-of-two modulus, the result equals the weighted sum truncated to B bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Capture `xIn` at this edge |
| xIn | input | NTERMS*B | Packed residues, term t in bits [t*B +: B] |
| outValid | output | 1 | `zOut` carries a new result this cycle |
| zOut | output | B | Registered modular inner product |

## Verification
Every result is due two rising edges after the edge that captured its inputs: one edge loads the input register and the next loads `zOut` and raises `outValid`. The bench drives on falling edges. For a single vector it compares `zOut` and `outValid` at the falling edge after the second rising edge. For streams it checks the result of vector k at the falling edge where vector k+2 is driven. For the hold scenario it samples once per cycle while `inValid` is low, so any stray load would show up in the cycle it happened.

// File: rtl/modConstDotPkg.sv
package modConstDotPkg;

  typedef struct packed {
    logic loadIn;
    logic loadOut;
  } dotStrobe_t;

  // residue of 2^b modulo m, used to replace a lost carry
  function automatic int unsigned carryFold(int unsigned m, int unsigned b);
    longint unsigned p;
    p = longint'(1) << b;
    return int'(p % longint'(m));
  endfunction

  // one entry of a constant-times-residue table
  function automatic int unsigned scaledResidue(int unsigned c, int unsigned a, int unsigned m);
    longint unsigned p;
    p = longint'(c) * longint'(a);
    return int'(p % longint'(m));
  endfunction

endpackage

// File: rtl/modConstMulTable.sv
module modConstMulTable
  import modConstDotPkg::*;
#(
  parameter int unsigned MOD  = 29,
  parameter int unsigned COEF = 3,
  parameter int unsigned B    = 5
) (
  input  logic [B-1:0] residue,
  output logic [B-1:0] product
);

  localparam int unsigned DEPTH = 1 << B;

  logic [B-1:0] tbl [DEPTH];

  // addresses at or above MOD are not residues; tie them to zero
  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    localparam int unsigned ENTRY = (a < MOD) ? scaledResidue(COEF, a, MOD) : 0;
    assign tbl[a] = B'(ENTRY);
  end

  assign product = tbl[residue];

endmodule

// File: rtl/modFoldAdder.sv
module modFoldAdder
  import modConstDotPkg::*;
#(
  parameter int unsigned MOD = 29,
  parameter int unsigned B   = 5
) (
  input  logic [B-1:0] opA,
  input  logic [B-1:0] opB,
  output logic [B-1:0] sum
);

  localparam logic [B-1:0] FOLD   = B'(carryFold(MOD, B));
  localparam logic [B:0]   MOD_W  = (B+1)'(MOD);
  localparam logic [B-1:0] MOD_LO = B'(MOD);

  logic [B:0]   rawSum;
  logic [B-1:0] folded;

  always_comb begin
    rawSum = {1'b0, opA} + {1'b0, opB};
    // operands below MOD keep low+FOLD inside B bits
    folded = rawSum[B] ? (rawSum[B-1:0] + FOLD) : rawSum[B-1:0];
    sum    = ({1'b0, folded} >= MOD_W) ? (folded - MOD_LO) : folded;
  end

endmodule

// File: rtl/modConstDotCtrl.sv
module modConstDotCtrl
  import modConstDotPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output dotStrobe_t strobe,
  output logic       outValid
);

  logic stageVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageVld <= 1'b0;
      outValid <= 1'b0;
    end else begin
      stageVld <= inValid;
      outValid <= stageVld;
    end
  end

  assign strobe.loadIn  = inValid;
  assign strobe.loadOut = stageVld;

endmodule

// File: rtl/modConstDotPath.sv
module modConstDotPath
  import modConstDotPkg::*;
#(
  parameter int unsigned MOD    = 29,
  parameter int unsigned NTERMS = 4,
  parameter int unsigned CW     = 16,
  parameter logic [NTERMS*CW-1:0] COEFS = '0,
  parameter int unsigned B      = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dotStrobe_t            strobe,
  input  logic [NTERMS*B-1:0]   xIn,
  output logic [B-1:0]          zOut
);

  logic [B-1:0] xReg  [NTERMS];
  logic [B-1:0] prod  [NTERMS];
  logic [B-1:0] accum [NTERMS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < NTERMS; t++) xReg[t] <= '0;
    end else if (strobe.loadIn) begin
      for (int t = 0; t < NTERMS; t++) xReg[t] <= xIn[t*B +: B];
    end
  end

  for (genvar t = 0; t < NTERMS; t++) begin : g_term
    modConstMulTable #(
      .MOD (MOD),
      .COEF(int'(COEFS[t*CW +: CW])),
      .B   (B)
    ) u_tbl (
      .residue(xReg[t]),
      .product(prod[t])
    );

    if (t == 0) begin : g_head
      assign accum[0] = prod[0];
    end else begin : g_link
      modFoldAdder #(
        .MOD(MOD),
        .B  (B)
      ) u_add (
        .opA(accum[t-1]),
        .opB(prod[t]),
        .sum(accum[t])
      );
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zOut <= '0;
    end else if (strobe.loadOut) begin
      zOut <= accum[NTERMS-1];
    end
  end

endmodule

// File: rtl/modConstDot.sv
module modConstDot
  import modConstDotPkg::*;
#(
  parameter int unsigned MOD    = 29,
  parameter int unsigned NTERMS = 4,
  parameter int unsigned CW     = 16,
  parameter logic [NTERMS*CW-1:0] COEFS = {16'd10, 16'd28, 16'd17, 16'd3},
  localparam int unsigned B     = $clog2(MOD)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [NTERMS*B-1:0] xIn,
  output logic                outValid,
  output logic [B-1:0]        zOut
);

  dotStrobe_t strobe;

  modConstDotCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  modConstDotPath #(
    .MOD   (MOD),
    .NTERMS(NTERMS),
    .CW    (CW),
    .COEFS (COEFS),
    .B     (B)
  ) u_path (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .xIn   (xIn),
    .zOut  (zOut)
  );

endmodule

// File: rtl/modConstDotChk.sv
module modConstDotChk #(
  parameter int unsigned MOD = 29,
  parameter int unsigned B   = 5
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         outValid,
  input logic [B-1:0] zOut
);

  localparam logic [B:0] MOD_W = (B+1)'(MOD);

  // R2
  accept_to_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  // R2
  result_has_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R3
  result_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ({1'b0, zOut} < MOD_W));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(zOut));

endmodule

bind modConstDot modConstDotChk #(
  .MOD(MOD),
  .B  (B)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .zOut    (zOut)
);

// File: tb/modConstDot_tb.sv
`timescale 1ns/1ps
module modConstDot_tb;

  localparam int MA = 29;
  localparam int BA = 5;
  localparam int NA = 4;
  localparam int CA [NA] = '{3, 17, 28, 10};

  localparam int MB = 16;
  localparam int BB = 4;
  localparam int NB = 3;
  localparam int CB [NB] = '{13, 9, 7};

  logic clk = 1'b0;
  logic rstN = 1'b0;

  logic              vA = 1'b0;
  logic [NA*BA-1:0]  xA = '0;
  logic              oA;
  logic [BA-1:0]     zA;

  logic              vB = 1'b0;
  logic [NB*BB-1:0]  xB = '0;
  logic              oB;
  logic [BB-1:0]     zB;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  modConstDot u_dut (
    .clk(clk), .rstN(rstN), .inValid(vA), .xIn(xA), .outValid(oA), .zOut(zA)
  );

  modConstDot #(
    .MOD(16), .NTERMS(3), .CW(16), .COEFS({16'd7, 16'd9, 16'd13})
  ) u_dutPow2 (
    .clk(clk), .rstN(rstN), .inValid(vB), .xIn(xB), .outValid(oB), .zOut(zB)
  );

  function automatic int refA(logic [NA*BA-1:0] x);
    int s = 0;
    for (int t = 0; t < NA; t++) begin
      int v = int'(x[t*BA +: BA]);
      if (v < MA) s += CA[t] * v;
    end
    return s % MA;
  endfunction

  function automatic int refB(logic [NB*BB-1:0] x);
    int s = 0;
    for (int t = 0; t < NB; t++) s += CB[t] * int'(x[t*BB +: BB]);
    return s % MB;
  endfunction

  function automatic logic [NA*BA-1:0] packA(int a0, int a1, int a2, int a3);
    return {BA'(a3), BA'(a2), BA'(a1), BA'(a0)};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic applyOne(logic [NA*BA-1:0] x, string req);
    @(negedge clk);
    vA = 1'b1; xA = x;
    @(negedge clk);
    vA = 1'b0; xA = '0;
    @(negedge clk);
    check({req, " valid"}, int'(oA), 1);
    check(req, int'(zA), refA(x));
    check("R3 range", int'(zA < BA'(MA)), 1);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(oA), 0);
    check("R1 z in reset", int'(zA), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", int'(oA), 0);
    check("R1 z after reset", int'(zA), 0);
  endtask

  task automatic testBasic();
    applyOne(packA(1, 0, 0, 0), "R2 unit term0");
    applyOne(packA(0, 1, 0, 0), "R2 unit term1");
    applyOne(packA(5, 7, 11, 13), "R2 mixed");
    applyOne(packA(2, 19, 4, 26), "R2 mixed2");
    applyOne(packA(0, 0, 0, 0), "R2 zero");
  endtask

  task automatic testCarry();
    applyOne(packA(28, 28, 28, 28), "R4 all max");
    applyOne(packA(28, 28, 0, 0), "R4 pair max");
    applyOne(packA(0, 27, 28, 25), "R4 near max");
  endtask

  task automatic testOutOfRange();
    applyOne(packA(31, 0, 0, 0), "R5 lone 31");
    applyOne(packA(29, 4, 30, 6), "R5 mixed illegal");
    applyOne(packA(31, 31, 31, 31), "R5 all illegal");
  endtask

  task automatic testHold();
    int held;
    applyOne(packA(9, 14, 3, 22), "R6 setup");
    held = int'(zA);
    for (int k = 0; k < 6; k++) begin
      xA = NA*BA'($urandom);
      @(negedge clk);
      check("R6 valid low", int'(oA), 0);
      check("R6 z held", int'(zA), held);
    end
    xA = '0;
  endtask

  task automatic testStream();
    logic [NA*BA-1:0] vec [6];
    for (int k = 0; k < 6; k++)
      vec[k] = packA($urandom_range(0, 28), $urandom_range(0, 28),
                     $urandom_range(0, 28), $urandom_range(0, 28));
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      if (t >= 2) begin
        check("R7 stream valid", int'(oA), 1);
        check("R7 stream value", int'(zA), refA(vec[t-2]));
      end
      if (t < 6) begin
        vA = 1'b1; xA = vec[t];
      end else begin
        vA = 1'b0; xA = '0;
      end
    end
    @(negedge clk);
    check("R7 stream end", int'(oA), 0);
  endtask

  task automatic testPow2();
    logic [NB*BB-1:0] x;
    for (int k = 0; k < 5; k++) begin
      x = (k == 0) ? '1 : NB*BB'($urandom);
      @(negedge clk);
      vB = 1'b1; xB = x;
      @(negedge clk);
      vB = 1'b0; xB = '0;
      @(negedge clk);
      check("R8 pow2 valid", int'(oB), 1);
      check("R8 pow2 value", int'(zB), refB(x));
    end
  endtask

  initial begin
    testReset();
    testBasic();
    testCarry();
    testOutOfRange();
    testHold();
    testStream();
    testPow2();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule